// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

The unit watches one asynchronous input pin and, when a chosen edge condition is met, stores the value of one of two free-running 16-bit timers in a four-entry first-in first-out store. The pin is first passed through a two-flop synchronizer. A rising or falling edge is then found by comparing the synchronized level with its value one clock earlier. The edge condition can be:

- any edge;
- falling edges only;
- rising edges only;
- every fourth rising edge;
- every sixteenth rising edge.

A 3-bit mode input selects the condition. A select bit chooses which timer is stored. A 2-bit count field sets how many capture events are needed before a sticky interrupt flag is raised.

The host drains stored stamps through a one-cycle read strobe and a registered read-data output. Two status outputs report whether the store holds data and whether a capture was lost. The control path is a state machine whose states mirror the decoded mode:

- **S_OFF**: no captures.
- **S_ANY**: capture on every edge.
- **S_FALL**: capture on falling edges.
- **S_RISE**: capture on rising edges.
- **S_DIV4**: capture on every fourth rising edge.
- **S_DIV16**: capture on every sixteenth rising edge.

Every clock, the state register moves to the state decoded from the mode input. When that move changes the state, it is a *reconfigure* transition: the prescale counter and the interrupt event counter are cleared in that cycle, and an edge seen in that cycle is not captured. While the state does not change (the *hold* transition), events are processed normally.

Top module: `edge_stamp`

## Requirements
- R1: While reset is asserted and after its release, before any capture, `rd_data`, `buf_not_empty`, `overflow` and `irq_flag` are all 0.
- R2: The pin passes two synchronizer flops. A level change driven before clock edge 1 is detected at edge 2 and stored at edge 3, so `buf_not_empty` rises after edge 3 and not before.
- R3: With mode 3'b011, each rising edge of the pin stores one timer sample and falling edges store nothing.
- R4: With mode 3'b010, each falling edge stores one sample and rising edges store nothing.
- R5: With mode 3'b001, every rising and every falling edge stores one sample.
- R6: Mode 3'b100 stores on the 4th, 8th, … rising edge. Mode 3'b101 stores on the 16th, 32nd, … rising edge, counted since the mode was entered.
- R7: The stored value is `timer_a` when `timer_sel` is 0 and `timer_b` when it is 1. It is taken in the clock cycle in which the edge is detected.
- R8: Up to four samples are held and returned in arrival order. `buf_not_empty` is 1 exactly while at least one sample is held.
- R9: A capture that arrives while four samples are held is dropped and sets `overflow`, even if a read happens in the same cycle. `overflow` stays set until a read leaves the store empty.
- R10: A read strobe while the store is empty leaves `rd_data` at the last value read. A successful read updates `rd_data` one clock later.
- R11: With `irq_count` = N, `irq_flag` is set on the (N+1)th capture event counted since the flag was last set or the mode last changed. Dropped captures also count. The flag stays set until `irq_clr`, and a set in the same cycle as `irq_clr` wins.
- R12: A change of decoded mode clears the prescale and interrupt counters and ignores an edge in that cycle. Mode 3'b000 and the codes 3'b110 and 3'b111 store nothing and keep the stored samples readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous pin to timestamp |
| timer_a | input | 16 | First timer value |
| timer_b | input | 16 | Second timer value |
| mode | input | 3 | Edge condition code |
| timer_sel | input | 1 | Timer choice, 1 = timer_b |
| irq_count | input | 2 | Captures per interrupt minus one |
| irq_clr | input | 1 | Clears the interrupt flag |
| rd_en | input | 1 | Read strobe, pops one sample |
| rd_data | output | 16 | Last sample read |
| buf_not_empty | output | 1 | Store holds at least one sample |
| overflow | output | 1 | A capture was dropped |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The assertions check, on every cycle, the properties that involve only one or two cycles:

- the flags stay sticky until cleared;
- `overflow` rises only when the store was full;
- an empty read leaves `rd_data` unchanged;
- an accepted capture makes the store non-empty;
- an off mode never adds a sample.

The bench's scenarios are needed for the counted behaviour, which spans many cycles:

- the prescaler ratios;
- the synchronizer latency;
- arrival order across wrap-around;
- the exact capture on which the interrupt rises;
- counter clearing on a reconfigure transition.

These are shown by comparing against the cycle-level reference model throughout directed and randomized stimulus.

// File: rtl/icap_pkg.sv
package icap_pkg;

    // state values equal the mode codes they stand for
    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_ANY   = 3'd1,
        S_FALL  = 3'd2,
        S_RISE  = 3'd3,
        S_DIV4  = 3'd4,
        S_DIV16 = 3'd5
    } cap_state_t;

    function automatic cap_state_t decode_mode(input logic [2:0] code);
        cap_state_t st;
        unique case (code)
            3'd1:    st = S_ANY;
            3'd2:    st = S_FALL;
            3'd3:    st = S_RISE;
            3'd4:    st = S_DIV4;
            3'd5:    st = S_DIV16;
            default: st = S_OFF;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise =  chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] &  last;

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import icap_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int CW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode,
    input  logic          rise,
    input  logic          fall,
    input  logic [CW-1:0] irq_count,
    input  logic          irq_clr,
    output logic          cap_event,
    output logic          irq_flag,
    output cap_state_t    state
);

    localparam int PW = $clog2(DIV_B) + 1;

    cap_state_t    state_q, state_d;
    logic          reconf;
    logic          edge_hit;
    logic [PW-1:0] pre_q, pre_d;
    logic [CW-1:0] cnt_q;
    logic          irq_hit;

    // state register: follows the decoded mode every cycle
    assign state_d = decode_mode(mode);
    assign reconf  = (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // outputs of the current state
    always_comb begin
        edge_hit = 1'b0;
        pre_d    = '0;
        unique case (state_q)
            S_OFF:   edge_hit = 1'b0;
            S_ANY:   edge_hit = rise | fall;
            S_FALL:  edge_hit = fall;
            S_RISE:  edge_hit = rise;
            S_DIV4: begin
                edge_hit = rise && (pre_q == PW'(DIV_A - 1));
                pre_d    = pre_q;
                if (rise) pre_d = edge_hit ? '0 : pre_q + 1'b1;
            end
            S_DIV16: begin
                edge_hit = rise && (pre_q == PW'(DIV_B - 1));
                pre_d    = pre_q;
                if (rise) pre_d = edge_hit ? '0 : pre_q + 1'b1;
            end
            default: edge_hit = 1'b0;
        endcase
        if (reconf) pre_d = '0;
    end

    assign cap_event = edge_hit && !reconf;
    assign irq_hit   = cap_event && (cnt_q >= irq_count);
    assign state     = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (reconf)     cnt_q <= '0;
        else if (irq_hit)    cnt_q <= '0;
        else if (cap_event)  cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (irq_hit) irq_flag <= 1'b1;
        else if (irq_clr) irq_flag <= 1'b0;
    end

endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [W-1:0]               wdata,
    input  logic                       rd,
    output logic [W-1:0]               rdata,
    output logic                       not_empty,
    output logic                       overflow,
    output logic [$clog2(DEPTH):0]     fill
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_wr, do_rd;

    assign full      = (fill == (AW+1)'(DEPTH));
    assign do_wr     = wr && !full;
    assign do_rd     = rd && (fill != '0);
    assign not_empty = (fill != '0);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            fill  <= '0;
            rdata <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) begin
                rp    <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
                rdata <= mem[rp];
            end
            if (do_wr && !do_rd)      fill <= fill + 1'b1;
            else if (do_rd && !do_wr) fill <= fill - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    overflow <= 1'b0;
        else if (wr && full)                           overflow <= 1'b1;
        else if (do_rd && !do_wr && fill == (AW+1)'(1)) overflow <= 1'b0;
    end

endmodule

// File: rtl/edge_stamp.sv
module edge_stamp
    import icap_pkg::*;
#(
    parameter int TW    = 16,
    parameter int DEPTH = 4,
    parameter int SYNC  = 2,
    parameter int DIV_A = 4,
    parameter int DIV_B = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_in,
    input  logic [TW-1:0] timer_a,
    input  logic [TW-1:0] timer_b,
    input  logic [2:0]    mode,
    input  logic          timer_sel,
    input  logic [1:0]    irq_count,
    input  logic          irq_clr,
    input  logic          rd_en,
    output logic [TW-1:0] rd_data,
    output logic          buf_not_empty,
    output logic          overflow,
    output logic          irq_flag
);

    localparam int FW = $clog2(DEPTH) + 1;

    logic          rise, fall;
    logic          cap_event;
    cap_state_t    ctl_state;
    logic [TW-1:0] stamp;
    logic [FW-1:0] fill;

    assign stamp = timer_sel ? timer_b : timer_a;

    pin_sync #(.STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_in),
        .rise  (rise),
        .fall  (fall)
    );

    cap_ctrl #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CW(2)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .rise      (rise),
        .fall      (fall),
        .irq_count (irq_count),
        .irq_clr   (irq_clr),
        .cap_event (cap_event),
        .irq_flag  (irq_flag),
        .state     (ctl_state)
    );

    stamp_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cap_event),
        .wdata     (stamp),
        .rd        (rd_en),
        .rdata     (rd_data),
        .not_empty (buf_not_empty),
        .overflow  (overflow),
        .fill      (fill)
    );

endmodule

// File: rtl/edge_stamp_chk.sv
module edge_stamp_chk #(
    parameter int TW    = 16,
    parameter int DEPTH = 4,
    parameter int FW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          irq_clr,
    input logic [TW-1:0] rd_data,
    input logic          buf_not_empty,
    input logic          overflow,
    input logic          irq_flag,
    input logic [FW-1:0] fill,
    input logic [2:0]    ctl_state,
    input logic          cap_event
);

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_not_empty && rd_en) |=> $stable(rd_data));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !rd_en) |=> overflow);

    assert_ovf_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(fill) == FW'(DEPTH)));

    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    assert_store_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_event && fill < FW'(DEPTH)) |=> buf_not_empty);

    assert_off_no_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == 3'd0 && !rd_en) |=> (fill == $past(fill)));

endmodule

bind edge_stamp edge_stamp_chk #(.TW(TW), .DEPTH(DEPTH), .FW(FW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .irq_clr       (irq_clr),
    .rd_data       (rd_data),
    .buf_not_empty (buf_not_empty),
    .overflow      (overflow),
    .irq_flag      (irq_flag),
    .fill          (fill),
    .ctl_state     (ctl_state),
    .cap_event     (cap_event)
);

// File: tb/tb_edge_stamp.sv
module tb_edge_stamp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] timer_a = '0;
    logic [15:0] timer_b = '0;
    logic [2:0]  mode = 3'd0;
    logic        timer_sel = 1'b0;
    logic [1:0]  irq_count = 2'd0;
    logic        irq_clr = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        buf_not_empty, overflow, irq_flag;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 0;

    always #4 clk = ~clk;   // 125 MHz

    edge_stamp dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .timer_a(timer_a), .timer_b(timer_b), .mode(mode),
        .timer_sel(timer_sel), .irq_count(irq_count), .irq_clr(irq_clr),
        .rd_en(rd_en), .rd_data(rd_data), .buf_not_empty(buf_not_empty),
        .overflow(overflow), .irq_flag(irq_flag)
    );

    // free-running timers, changed away from the active edge
    int tcount = 0;
    always @(negedge clk) begin
        tcount  = tcount + 1;
        timer_a = 16'(tcount);
        timer_b = 16'hA000 ^ 16'(tcount * 7);
    end

    // behavioural reference model
    logic [15:0] q[$];
    bit   m_s1, m_s2, m_last;
    int   m_st, m_pre, m_cnt;
    bit   m_irq, m_ov;
    logic [15:0] m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            m_s1 = 0; m_s2 = 0; m_last = 0;
            m_st = 0; m_pre = 0; m_cnt = 0;
            m_irq = 0; m_ov = 0; m_rd = '0;
        end else begin
            int  dec, presize;
            bit  rise, fall, chg, hit, ev, full, rdok, wrok;
            dec  = (mode <= 3'd5) ? int'(mode) : 0;
            rise = m_s2 && !m_last;
            fall = !m_s2 && m_last;
            chg  = (dec != m_st);
            case (m_st)
                1: hit = rise || fall;
                2: hit = fall;
                3: hit = rise;
                4: hit = rise && (m_pre == 3);
                5: hit = rise && (m_pre == 15);
                default: hit = 0;
            endcase
            ev = hit && !chg;
            presize = q.size();
            full = (presize == 4);
            rdok = rd_en && presize > 0;
            wrok = ev && !full;
            if (rdok) m_rd = q.pop_front();
            if (wrok) q.push_back(timer_sel ? timer_b : timer_a);
            if (ev && full) m_ov = 1;
            else if (rdok && presize == 1 && !wrok) m_ov = 0;
            if (chg) m_cnt = 0;
            else if (ev) begin
                if (m_cnt >= int'(irq_count)) begin m_cnt = 0; m_irq = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (!(ev && !chg && m_cnt == 0 && m_irq) && irq_clr) m_irq = 0;
            if (chg || !(m_st == 4 || m_st == 5)) m_pre = 0;
            else if (rise) m_pre = hit ? 0 : m_pre + 1;
            m_st = dec;
            m_last = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    task automatic chk(input string t, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag, "rd_data", rd_data, m_rd);
            chk(tag, "buf_not_empty", 16'(buf_not_empty), 16'(q.size() > 0));
            chk(tag, "overflow", 16'(overflow), 16'(m_ov));
            chk(tag, "irq_flag", 16'(irq_flag), 16'(m_irq));
        end
    end

    task automatic pulse(input int hi, input int lo);
        pin_in = 1'b1;
        repeat (hi) @(negedge clk);
        pin_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            rd_en = 1'b1; @(negedge clk);
            rd_en = 1'b0; @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual hung expected finished");
        finish_run();
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        chk("R1", "rd_data in reset", rd_data, 16'h0);
        chk("R1", "flags in reset", {13'd0, buf_not_empty, overflow, irq_flag}, 16'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 latency and R3 rising capture
        tag = "R3"; mode = 3'd3; irq_count = 2'd3;
        repeat (3) @(negedge clk);
        pin_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "not_empty after 2 edges", 16'(buf_not_empty), 16'h0);
        @(negedge clk);
        chk("R2", "not_empty after 3 edges", 16'(buf_not_empty), 16'h1);
        pin_in = 1'b0;
        repeat (3) @(negedge clk);
        // four more rising edges, last one overflows
        tag = "R9";
        repeat (4) pulse(3, 3);
        repeat (4) @(negedge clk);
        chk("R9", "overflow after fifth capture", 16'(overflow), 16'h1);
        tag = "R8"; drain(3);
        chk("R9", "overflow kept while not empty", 16'(overflow), 16'h1);
        drain(1);
        chk("R9", "overflow cleared when empty", 16'(overflow), 16'h0);
        tag = "R10"; drain(2);
        chk("R10", "empty read keeps value", 16'(buf_not_empty), 16'h0);

        // R4 falling with R7 timer choice
        tag = "R4"; mode = 3'd2; timer_sel = 1'b1;
        repeat (3) pulse(2, 4);
        repeat (4) @(negedge clk);
        tag = "R7"; drain(4);
        timer_sel = 1'b0;

        // R5 both edges
        tag = "R5"; mode = 3'd1;
        repeat (2) pulse(3, 3);
        repeat (4) @(negedge clk);
        drain(5);

        // R6 prescaled rising
        tag = "R6"; mode = 3'd4;
        repeat (9) pulse(2, 2);
        repeat (4) @(negedge clk);
        drain(3);
        mode = 3'd5;
        repeat (17) pulse(2, 2);
        repeat (4) @(negedge clk);
        drain(2);

        // R11 interrupt count and clear
        tag = "R11"; mode = 3'd3; irq_count = 2'd2;
        for (int i = 0; i < 7; i++) begin
            pulse(2, 3);
            rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
            if (i == 3) begin irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; end
        end
        irq_clr = 1'b1; repeat (2) @(negedge clk); irq_clr = 1'b0;
        irq_count = 2'd0;
        pulse(2, 3);
        repeat (2) @(negedge clk);
        chk("R11", "flag after one capture with N=0", 16'(irq_flag), 16'h1);
        drain(4);

        // R12 mode change clears prescaler, off codes keep data
        tag = "R12"; mode = 3'd4; irq_count = 2'd3;
        repeat (3) pulse(2, 2);
        mode = 3'd5; @(negedge clk); mode = 3'd4;
        repeat (3) pulse(2, 2);
        repeat (4) @(negedge clk);
        chk("R12", "no capture after prescaler reset", 16'(buf_not_empty), 16'h0);
        pulse(2, 2);
        repeat (4) @(negedge clk);
        chk("R12", "capture on fourth after reset", 16'(buf_not_empty), 16'h1);
        mode = 3'd6;
        repeat (4) pulse(2, 2);
        mode = 3'd0;
        repeat (3) pulse(2, 2);
        repeat (4) @(negedge clk);
        chk("R12", "off keeps one entry", 16'(buf_not_empty), 16'h1);
        drain(2);

        // randomized mix
        tag = "R12";
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 3) == 0) pin_in = ~pin_in;
            rd_en   = ($urandom_range(0, 5) == 0);
            irq_clr = ($urandom_range(0, 7) == 0);
            if (c % 250 == 0) begin
                mode      = 3'($urandom_range(0, 7));
                timer_sel = 1'($urandom_range(0, 1));
                irq_count = 2'($urandom_range(0, 3));
            end
            @(negedge clk);
        end
        rd_en = 1'b0; irq_clr = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule